// File: doc/BRIEF.md
# Byte ALU with Selective Status Update

This block is the 8-bit datapath of an accumulator-style microcontroller core. Each cycle it takes an operation code, the working register value W, a file operand f and a literal k. It produces a byte result at once, combinationally. A five-bit status register (negative, signed overflow, carry, digit carry, zero) and a 16-bit product register are updated on the clock edge when the op-valid strobe is high.

Every operation owns a fixed subset of the status bits. Only those bits are written, and all other bits keep their stored value. Subtraction treats carry as an inverted borrow. The unit also provides nibble swap, decimal adjust of W, and an unsigned 8x8 multiply. Writing the result back and decoding instruction words happen outside this block. The operation code arrives here already decoded.

Top module: `byte_alu`

## Requirements
- R1: On reset, status_o and prod_o are zero. The status bit positions are C=0, DC=1, Z=2, OV=3, N=4.
- R2: Add operations are code 0 (W+f), code 1 (W+k) and code 2 (W+f+C). They update all five flags: N is result bit 7, DC is the carry out of bit 3, OV is two's-complement overflow, and C is the carry out of bit 7.
- R3: Subtract operations are code 3 (f-W), code 4 (f-W-!C), code 5 (W-f-!C) and code 6 (k-W). They update all five flags, and C and DC are set when no borrow occurs.
- R4: Code 14 increments f, code 15 decrements f and code 16 computes 0-f. All three update all five flags, with the same carry, borrow and overflow rules as R2 and R3.
- R5: Logic operations are codes 7 and 8 (AND with f or k), codes 9 and 10 (OR), and codes 11 and 12 (XOR). They update only N and Z.
- R6: Code 13 (complement f) and code 24 (move f) update only N and Z.
- R7: Code 17 rotates f left through C, and code 18 rotates f right through C. The bit shifted out goes to C, and N and Z are updated.
- R8: Code 19 rotates f left without carry, and code 20 rotates f right without carry. Both update only N and Z.
- R9: Code 21 exchanges the two nibbles of f and changes no flag.
- R10: Code 22 returns 0x00 and sets Z, leaving the other flags unchanged. Code 23 returns 0xFF and changes no flag.
- R11: Code 25 (W*f) and code 26 (W*k) load the unsigned 16-bit product into prod_o. They drive result_o to 0 and change no flag.
- R12: Code 27 adds 0x06 to W when W[3:0]>9 or DC=1, and adds 0x60 when W[7:4]>9 or C=1. It changes only C, which becomes the carry out of that addition ORed with the old C.
- R13: When op_valid_i is low, status_o and prod_o hold their values. Codes 28 to 31 give result 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Commit strobe for status and product |
| op_i | input | 5 | Operation code |
| w_i | input | 8 | Working register value |
| f_i | input | 8 | File operand |
| k_i | input | 8 | Literal operand |
| result_o | output | 8 | Combinational result byte |
| prod_o | output | 16 | Registered product |
| status_o | output | 5 | Registered flags {N,OV,Z,DC,C} |

## Verification
The hardest behaviour to reach is a flag bit surviving several operations that do not own it. An example is a DC value from an add that must persist through rotates, logic operations and a decimal adjust that reads it. Random operation streams with the strobe dropped about one cycle in five never reset between operations, so stale flags carry forward and are read by later carry-consuming codes. Directed sequences add the edges of the arithmetic: 0x7F+1, 0xFF+1, negating 0x80 and 0x00, decrementing 0x00, and a decimal adjust with both corrections active.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned FL_C   = 0;
  localparam int unsigned FL_DC  = 1;
  localparam int unsigned FL_Z   = 2;
  localparam int unsigned FL_OV  = 3;
  localparam int unsigned FL_N   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_F  = 5'd0,  OP_ADD_K  = 5'd1,  OP_ADDC_F = 5'd2,
    OP_SUB_F  = 5'd3,  OP_SUBB_F = 5'd4,  OP_SUBB_W = 5'd5,  OP_SUB_K = 5'd6,
    OP_AND_F  = 5'd7,  OP_AND_K  = 5'd8,  OP_OR_F   = 5'd9,  OP_OR_K  = 5'd10,
    OP_XOR_F  = 5'd11, OP_XOR_K  = 5'd12, OP_COM    = 5'd13,
    OP_INC    = 5'd14, OP_DEC    = 5'd15, OP_NEG    = 5'd16,
    OP_RLC    = 5'd17, OP_RRC    = 5'd18, OP_RLN    = 5'd19, OP_RRN   = 5'd20,
    OP_SWAP   = 5'd21, OP_CLR    = 5'd22, OP_SET    = 5'd23, OP_MOV   = 5'd24,
    OP_MUL_F  = 5'd25, OP_MUL_K  = 5'd26, OP_DAW    = 5'd27
  } alu_op_e;

  localparam logic [FLAG_W-1:0] M_ALL  = 5'b11111;
  localparam logic [FLAG_W-1:0] M_NZ   = 5'b10100;
  localparam logic [FLAG_W-1:0] M_NZC  = 5'b10101;
  localparam logic [FLAG_W-1:0] M_Z    = 5'b00100;
  localparam logic [FLAG_W-1:0] M_C    = 5'b00001;
  localparam logic [FLAG_W-1:0] M_NONE = 5'b00000;

  function automatic logic is_arith(input logic [OP_W-1:0] op);
    return (op <= OP_SUB_K) || (op == OP_INC) || (op == OP_DEC) || (op == OP_NEG);
  endfunction

  function automatic logic [FLAG_W-1:0] flag_mask(input logic [OP_W-1:0] op);
    logic [FLAG_W-1:0] m;
    case (op)
      OP_AND_F, OP_AND_K, OP_OR_F, OP_OR_K, OP_XOR_F, OP_XOR_K,
      OP_COM, OP_RLN, OP_RRN, OP_MOV:                              m = M_NZ;
      OP_RLC, OP_RRC:                                              m = M_NZC;
      OP_CLR:                                                      m = M_Z;
      OP_DAW:                                                      m = M_C;
      default:                                                     m = is_arith(op) ? M_ALL : M_NONE;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             dc_o,
  output logic             ov_o
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH:0] full;
  logic [HALF:0]  low;

  assign full  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign low   = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
  assign sum_o = full[WIDTH-1:0];
  assign c_o   = full[WIDTH];
  assign dc_o  = low[HALF];
  // overflow: like-signed operands, result sign differs
  assign ov_o  = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
endmodule

// File: rtl/byte_alu_bitops.sv
module byte_alu_bitops
  import byte_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] f_i,
  input  logic [WIDTH-1:0] k_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o
);
  localparam int unsigned HALF = WIDTH / 2;

  always_comb begin
    res_o = '0;
    c_o   = c_i;
    case (op_i)
      OP_AND_F: res_o = w_i & f_i;
      OP_AND_K: res_o = w_i & k_i;
      OP_OR_F:  res_o = w_i | f_i;
      OP_OR_K:  res_o = w_i | k_i;
      OP_XOR_F: res_o = w_i ^ f_i;
      OP_XOR_K: res_o = w_i ^ k_i;
      OP_COM:   res_o = ~f_i;
      OP_MOV:   res_o = f_i;
      OP_RLC: begin
        res_o = {f_i[WIDTH-2:0], c_i};
        c_o   = f_i[WIDTH-1];
      end
      OP_RRC: begin
        res_o = {c_i, f_i[WIDTH-1:1]};
        c_o   = f_i[0];
      end
      OP_RLN:   res_o = {f_i[WIDTH-2:0], f_i[WIDTH-1]};
      OP_RRN:   res_o = {f_i[0], f_i[WIDTH-1:1]};
      OP_SWAP:  res_o = {f_i[HALF-1:0], f_i[WIDTH-1:HALF]};
      OP_CLR:   res_o = '0;
      OP_SET:   res_o = '1;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/byte_alu_decadj.sv
module byte_alu_decadj #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] w_i,
  input  logic             c_i,
  input  logic             dc_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o
);
  localparam int unsigned HALF = WIDTH / 2;
  localparam int unsigned HIW  = WIDTH - HALF;

  logic             lo_fix, hi_fix;
  logic [WIDTH-1:0] corr;
  logic [WIDTH:0]   sum;

  assign lo_fix = (w_i[HALF-1:0] > HALF'(9)) || dc_i;
  assign hi_fix = (w_i[WIDTH-1:HALF] > HIW'(9)) || c_i;
  assign corr   = {(hi_fix ? HIW'(6) : HIW'(0)), (lo_fix ? HALF'(6) : HALF'(0))};
  assign sum    = {1'b0, w_i} + {1'b0, corr};
  assign res_o  = sum[WIDTH-1:0];
  assign c_o    = sum[WIDTH] | c_i;
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic [WIDTH-1:0]     w_i,
  input  logic [WIDTH-1:0]     f_i,
  input  logic [WIDTH-1:0]     k_i,
  output logic [WIDTH-1:0]     result_o,
  output logic [2*WIDTH-1:0]   prod_o,
  output logic [FLAG_W-1:0]    status_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [FLAG_W-1:0] status_q;
  logic [PW-1:0]     prod_q;
  logic              c_cur, dc_cur;

  assign c_cur  = status_q[FL_C];
  assign dc_cur = status_q[FL_DC];

  // adder operand steering; subtraction as a + ~b + cin
  logic [WIDTH-1:0] add_a, add_b;
  logic             add_cin;
  always_comb begin
    add_a   = '0;
    add_b   = '0;
    add_cin = 1'b0;
    case (op_i)
      OP_ADD_F:  begin add_a = w_i; add_b = f_i;  add_cin = 1'b0;  end
      OP_ADD_K:  begin add_a = w_i; add_b = k_i;  add_cin = 1'b0;  end
      OP_ADDC_F: begin add_a = w_i; add_b = f_i;  add_cin = c_cur; end
      OP_SUB_F:  begin add_a = f_i; add_b = ~w_i; add_cin = 1'b1;  end
      OP_SUBB_F: begin add_a = f_i; add_b = ~w_i; add_cin = c_cur; end
      OP_SUBB_W: begin add_a = w_i; add_b = ~f_i; add_cin = c_cur; end
      OP_SUB_K:  begin add_a = k_i; add_b = ~w_i; add_cin = 1'b1;  end
      OP_INC:    begin add_a = f_i; add_b = '0;   add_cin = 1'b1;  end
      OP_DEC:    begin add_a = f_i; add_b = '1;   add_cin = 1'b0;  end
      OP_NEG:    begin add_a = '0;  add_b = ~f_i; add_cin = 1'b1;  end
      default:   ;
    endcase
  end

  logic [WIDTH-1:0] add_sum;
  logic             add_c, add_dc, add_ov;
  byte_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
    .sum_o(add_sum), .c_o(add_c), .dc_o(add_dc), .ov_o(add_ov)
  );

  logic [WIDTH-1:0] bit_res;
  logic             bit_c;
  byte_alu_bitops #(.WIDTH(WIDTH)) u_bitops (
    .op_i(op_i), .w_i(w_i), .f_i(f_i), .k_i(k_i), .c_i(c_cur),
    .res_o(bit_res), .c_o(bit_c)
  );

  logic [WIDTH-1:0] daw_res;
  logic             daw_c;
  byte_alu_decadj #(.WIDTH(WIDTH)) u_decadj (
    .w_i(w_i), .c_i(c_cur), .dc_i(dc_cur), .res_o(daw_res), .c_o(daw_c)
  );

  logic arith_sel, daw_sel, mul_sel;
  assign arith_sel = is_arith(op_i);
  assign daw_sel   = (op_i == OP_DAW);
  assign mul_sel   = (op_i == OP_MUL_F) || (op_i == OP_MUL_K);

  always_comb begin
    if (arith_sel)    result_o = add_sum;
    else if (daw_sel) result_o = daw_res;
    else              result_o = bit_res;
  end

  logic [FLAG_W-1:0] cand, mask;
  always_comb begin
    cand        = '0;
    cand[FL_N]  = result_o[WIDTH-1];
    cand[FL_Z]  = (result_o == '0);
    cand[FL_OV] = add_ov;
    cand[FL_DC] = add_dc;
    cand[FL_C]  = arith_sel ? add_c : (daw_sel ? daw_c : bit_c);
    mask        = flag_mask(op_i);
  end

  logic [WIDTH-1:0] mul_b;
  logic [PW-1:0]    prod_d;
  assign mul_b  = (op_i == OP_MUL_K) ? k_i : f_i;
  assign prod_d = PW'(w_i) * PW'(mul_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      prod_q   <= '0;
    end else if (op_valid_i) begin
      status_q <= (cand & mask) | (status_q & ~mask);
      if (mul_sel) prod_q <= prod_d;
    end
  end

  assign status_o = status_q;
  assign prod_o   = prod_q;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import byte_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_valid_i,
  input logic [OP_W-1:0]    op_i,
  input logic [WIDTH-1:0]   w_i,
  input logic [WIDTH-1:0]   f_i,
  input logic [WIDTH-1:0]   k_i,
  input logic [WIDTH-1:0]   result_o,
  input logic [2*WIDTH-1:0] prod_o,
  input logic [FLAG_W-1:0]  status_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic logic_op;
  assign logic_op = (op_i >= OP_AND_F) && (op_i <= OP_XOR_K);

  a_r13_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> ($stable(status_o) && $stable(prod_o)));

  a_r9_swap_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_SWAP) |=> $stable(status_o));

  a_r5_logic_keeps_c_dc_ov: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && logic_op) |=>
      (status_o[FL_C] == $past(status_o[FL_C]) && status_o[FL_DC] == $past(status_o[FL_DC])
       && status_o[FL_OV] == $past(status_o[FL_OV])));

  a_r10_clear_sets_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_CLR) |=> status_o[FL_Z]);

  a_r11_mul_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_MUL_F) |=> (prod_o == PW'($past(w_i)) * PW'($past(f_i))));

  a_r2_n_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i <= OP_ADDC_F) |=> (status_o[FL_N] == $past(result_o[WIDTH-1])));

  a_r12_daw_only_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_DAW) |=> (status_o[FLAG_W-1:1] == $past(status_o[FLAG_W-1:1])));
endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [7:0]  w_i = '0, f_i = '0, k_i = '0;
  logic [7:0]  result_o;
  logic [15:0] prod_o;
  logic [4:0]  status_o;

  int checks = 0;
  int errors = 0;
  logic [4:0]  exp_st = '0;
  logic [15:0] exp_pr = '0;

  always #2.5 clk_i = ~clk_i;

  byte_alu u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5'd2) return "R2";
    if (op <= 5'd6) return "R3";
    if (op <= 5'd12) return "R5";
    if (op == 5'd13 || op == 5'd24) return "R6";
    if (op <= 5'd16) return "R4";
    if (op <= 5'd18) return "R7";
    if (op <= 5'd20) return "R8";
    if (op == 5'd21) return "R9";
    if (op <= 5'd23) return "R10";
    if (op <= 5'd26) return "R11";
    if (op == 5'd27) return "R12";
    return "R13";
  endfunction

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // returns {n,ov,z,dc,c} candidate flags and result via outputs
  task automatic addm(input int x, input int y, input int ci, output logic [7:0] r, output logic [4:0] fl);
    int s, sv;
    s = x + y + ci;
    sv = sgn(x) + sgn(y) + ci;
    r = s[7:0];
    fl = {r[7], (sv < -128 || sv > 127), (r == 0), ((x % 16 + y % 16 + ci) > 15), (s > 255)};
  endtask

  task automatic subm(input int x, input int y, input int bo, output logic [7:0] r, output logic [4:0] fl);
    int d, sv;
    d = x - y - bo;
    sv = sgn(x) - sgn(y) - bo;
    r = d[7:0];
    fl = {r[7], (sv < -128 || sv > 127), (r == 0), ((x % 16 - y % 16 - bo) >= 0), (d >= 0)};
  endtask

  task automatic model(input logic [4:0] op, input logic [7:0] w, f, k, input logic [4:0] st,
                       output logic [7:0] r, output logic [4:0] ns, output logic [15:0] pr, output logic pl);
    logic [4:0] fl, m;
    int c, s, corr;
    c = int'(st[0]);
    r = 8'h00; fl = 5'b0; m = 5'b0; pl = 1'b0; pr = 16'h0;
    case (op)
      5'd0:  begin addm(w, f, 0, r, fl); m = 5'b11111; end
      5'd1:  begin addm(w, k, 0, r, fl); m = 5'b11111; end
      5'd2:  begin addm(w, f, c, r, fl); m = 5'b11111; end
      5'd3:  begin subm(f, w, 0, r, fl); m = 5'b11111; end
      5'd4:  begin subm(f, w, 1 - c, r, fl); m = 5'b11111; end
      5'd5:  begin subm(w, f, 1 - c, r, fl); m = 5'b11111; end
      5'd6:  begin subm(k, w, 0, r, fl); m = 5'b11111; end
      5'd14: begin addm(f, 1, 0, r, fl); m = 5'b11111; end
      5'd15: begin subm(f, 1, 0, r, fl); m = 5'b11111; end
      5'd16: begin subm(0, f, 0, r, fl); m = 5'b11111; end
      5'd7:  begin r = w & f; m = 5'b10100; end
      5'd8:  begin r = w & k; m = 5'b10100; end
      5'd9:  begin r = w | f; m = 5'b10100; end
      5'd10: begin r = w | k; m = 5'b10100; end
      5'd11: begin r = w ^ f; m = 5'b10100; end
      5'd12: begin r = w ^ k; m = 5'b10100; end
      5'd13: begin r = ~f; m = 5'b10100; end
      5'd24: begin r = f; m = 5'b10100; end
      5'd17: begin r = {f[6:0], st[0]}; fl[0] = f[7]; m = 5'b10101; end
      5'd18: begin r = {st[0], f[7:1]}; fl[0] = f[0]; m = 5'b10101; end
      5'd19: begin r = {f[6:0], f[7]}; m = 5'b10100; end
      5'd20: begin r = {f[0], f[7:1]}; m = 5'b10100; end
      5'd21: begin r = {f[3:0], f[7:4]}; end
      5'd22: begin r = 8'h00; m = 5'b00100; end
      5'd23: begin r = 8'hFF; end
      5'd25: begin pl = 1'b1; pr = 16'(int'(w) * int'(f)); end
      5'd26: begin pl = 1'b1; pr = 16'(int'(w) * int'(k)); end
      5'd27: begin
        corr = ((w % 16 > 9) || st[1]) ? 6 : 0;
        corr += ((w / 16 > 9) || st[0]) ? 96 : 0;
        s = int'(w) + corr;
        r = s[7:0];
        fl[0] = (s > 255) || st[0];
        m = 5'b00001;
      end
      default: ;
    endcase
    fl[4] = r[7];
    fl[2] = (op == 5'd22) ? 1'b1 : (r == 0);
    ns = (fl & m) | (st & ~m);
  endtask

  task automatic do_op(input logic v, input logic [4:0] op, input logic [7:0] w, f, k);
    logic [7:0] r; logic [4:0] ns; logic [15:0] pr; logic pl;
    string rq;
    @(negedge clk_i);
    op_valid_i = v; op_i = op; w_i = w; f_i = f; k_i = k;
    #1;
    model(op, w, f, k, exp_st, r, ns, pr, pl);
    rq = req_of(op);
    chk({rq, " result"}, 16'(result_o), 16'(r));
    @(posedge clk_i);
    #1;
    if (v) begin
      exp_st = ns;
      if (pl) exp_pr = pr;
    end
    chk(v ? {rq, " status"} : "R13 status hold", 16'(status_o), 16'(exp_st));
    chk(v ? {rq, " product"} : "R13 product hold", prod_o, exp_pr);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'hA1B2));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 status reset", 16'(status_o), 16'h0);
    chk("R1 product reset", prod_o, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 edges: signed overflow with DC, then wrap to zero with C
    do_op(1, 5'd1, 8'h7F, 8'h00, 8'h01);
    do_op(1, 5'd0, 8'hFF, 8'h01, 8'h00);
    do_op(1, 5'd2, 8'h10, 8'h20, 8'h00);   // R2 carry-in consumed
    // R3: equal operands, borrow, borrow chain
    do_op(1, 5'd3, 8'h42, 8'h42, 8'h00);
    do_op(1, 5'd3, 8'h43, 8'h42, 8'h00);
    do_op(1, 5'd4, 8'h01, 8'h05, 8'h00);
    do_op(1, 5'd5, 8'h80, 8'h01, 8'h00);
    do_op(1, 5'd6, 8'h10, 8'h00, 8'h05);
    // R4 edges
    do_op(1, 5'd16, 8'h00, 8'h80, 8'h00);
    do_op(1, 5'd16, 8'h00, 8'h00, 8'h00);
    do_op(1, 5'd15, 8'h00, 8'h00, 8'h00);
    do_op(1, 5'd14, 8'h00, 8'hFF, 8'h00);
    do_op(1, 5'd14, 8'h00, 8'h7F, 8'h00);
    // R7 / R8 rotates
    do_op(1, 5'd17, 8'h00, 8'h81, 8'h00);
    do_op(1, 5'd18, 8'h00, 8'h01, 8'h00);
    do_op(1, 5'd19, 8'h00, 8'h80, 8'h00);
    do_op(1, 5'd20, 8'h00, 8'h01, 8'h00);
    // R9, R10, R6, R5
    do_op(1, 5'd21, 8'h00, 8'hA5, 8'h00);
    do_op(1, 5'd22, 8'h00, 8'h00, 8'h00);
    do_op(1, 5'd23, 8'h00, 8'h00, 8'h00);
    do_op(1, 5'd13, 8'h00, 8'hFF, 8'h00);
    do_op(1, 5'd24, 8'h00, 8'h80, 8'h00);
    do_op(1, 5'd11, 8'h5A, 8'h5A, 8'h00);
    // R11 multiply extremes
    do_op(1, 5'd25, 8'hFF, 8'hFF, 8'h00);
    do_op(1, 5'd26, 8'h12, 8'h00, 8'h34);
    // R12: both corrections, then via DC flag
    do_op(1, 5'd22, 8'h00, 8'h00, 8'h00);
    do_op(1, 5'd27, 8'h9A, 8'h00, 8'h00);
    do_op(1, 5'd0, 8'h09, 8'h09, 8'h00);
    do_op(1, 5'd27, 8'h12, 8'h00, 8'h00);
    // R13: strobe low and unused codes
    do_op(0, 5'd25, 8'h33, 8'h44, 8'h00);
    do_op(0, 5'd22, 8'h00, 8'h00, 8'h00);
    do_op(1, 5'd29, 8'hFF, 8'hFF, 8'hFF);

    for (int i = 0; i < 3000; i++) begin
      do_op(($urandom % 5) != 0, 5'($urandom_range(0, 31)),
            8'($urandom), 8'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule